// File: doc/BRIEF.md
# Home-Node Presence-Vector Directory Controller

This block keeps the coherence record for every memory line homed at one node of a small shared-memory machine. Each line's record holds one dirty flag and an exact presence vector, one bit per processor. A processor asks for a line to read or to write. The controller looks up the record and works through the coherence steps the request needs. It may read memory, pull a dirty copy back from its owner, write that copy back to memory, or send invalidations to every other sharer at once and count their acknowledgements. It then rewrites the record and returns a grant with the line's data.

Only one transaction runs at a time. A ready signal holds off new requests until the grant has gone out. The network, the caches and any data storage beyond one line-sized holding register belong to the surrounding logic. The default build has 8 processors, 256 lines and 32-bit line data.

Top module: `coh_home_dir`

## Requirements
- R1: After reset `req_ready` is 1 and no grant, memory, recall or invalidation output is active. Every record is empty: clean, with no presence bits set.
- R2: A read of a clean line causes exactly one memory read, with no recall and no invalidation. The grant carries the memory data. The requester is added to the presence vector, so a later write by another processor invalidates it.
- R3: A read of a line that is dirty at another processor sends that owner a recall with `recall_excl`=0. The recalled data is then written to memory, and the grant carries the recalled data. Afterwards the line is clean, and both the old owner and the requester are sharers.
- R4: A write to a clean line raises `inv_valid` for exactly one cycle, with one bit per sharer other than the requester (bit n means processor n). If no other sharer exists, no invalidation is sent.
- R5: No grant is issued until every processor in the invalidation mask has acknowledged on its `inv_ack` bit. Acknowledgements from processors outside the pending set are ignored.
- R6: After the invalidations, a write to a clean line reads memory once and grants with the memory data and `grant_write`=1. Afterwards the line is dirty, and the requester is its only holder.
- R7: A write to a line that is dirty at another processor sends that owner a recall with `recall_excl`=1. Memory is not written. The grant carries the recalled data, and the requester becomes the sole dirty owner.
- R8: A read or a write from the processor that already owns the dirty line is granted with data 0. It sends no message and leaves the record unchanged.
- R9: `req_ready` is 0 from the cycle after a request is accepted until the grant has gone out. Requests offered in that time are not taken.
- R10: Memory, recall and invalidation requests are held until their matching done input arrives, and they carry the request's line on `txn_line`. The grant is a single-cycle pulse that returns the request's processor and line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and taking a request |
| req_write | input | 1 | 1 = write (exclusive) request, 0 = read |
| req_node | input | 3 | Requesting processor |
| req_line | input | 8 | Line index |
| txn_line | output | 8 | Line of the transaction in progress |
| mem_rd_valid | output | 1 | Memory read request |
| mem_wr_valid | output | 1 | Memory write-back request |
| mem_wr_data | output | 32 | Data to write to memory |
| mem_done | input | 1 | Memory completes the current request |
| mem_rd_data | input | 32 | Memory read data, valid with mem_done |
| recall_valid | output | 1 | Recall of the dirty copy |
| recall_excl | output | 1 | 1 = owner invalidates, 0 = owner keeps a shared copy |
| recall_node | output | 3 | Owner being recalled |
| recall_done | input | 1 | Owner returned its copy |
| recall_data | input | 32 | Recalled data, valid with recall_done |
| inv_valid | output | 8 | Invalidation pulse, one bit per processor |
| inv_ack | input | 8 | Invalidation acknowledgements, one bit per processor |
| grant_valid | output | 1 | Grant pulse |
| grant_write | output | 1 | Grant is for a write |
| grant_node | output | 3 | Processor being granted |
| grant_line | output | 8 | Granted line |
| grant_data | output | 32 | Line data returned |

## Verification
A request is taken on the rising edge where it meets `req_ready`. The record lookup happens the next cycle, so the first memory, recall or invalidation request is visible two edges after acceptance. Each done input is consumed on the edge that samples it. After the last acknowledgement, one more edge passes before the tracker reports completion and the memory read starts. The bench drives and samples only on falling edges. It reacts to whichever request is visible at that moment instead of assuming fixed latencies. It checks that the invalidation pulse and the grant each last exactly one sample, and that `req_ready` is back at the sample after the grant. Response latencies and acknowledgement orders are randomized, so the grant cycle moves, while every expected value comes from a reference record kept in the bench.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;
    localparam int unsigned NODES  = 8;
    localparam int unsigned LINES  = 256;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned NODE_W = $clog2(NODES);
    localparam int unsigned LINE_W = $clog2(LINES);
    localparam int unsigned CNT_W  = $clog2(NODES + 1);

    typedef logic [NODES-1:0]  node_mask_t;
    typedef logic [NODE_W-1:0] node_id_t;
    typedef logic [LINE_W-1:0] line_idx_t;
    typedef logic [DATA_W-1:0] line_data_t;

    typedef struct packed {
        logic       dirty;
        node_mask_t present;
    } dir_entry_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECIDE,
        ST_INV,
        ST_WAIT_ACK,
        ST_MEM_RD,
        ST_RECALL,
        ST_MEM_WR,
        ST_GRANT
    } dir_state_e;
endpackage

// File: rtl/coh_dir_store.sv
module coh_dir_store
    import coh_dir_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  line_idx_t  rd_line,
    output dir_entry_t rd_entry,
    input  logic       wr_en,
    input  line_idx_t  wr_line,
    input  dir_entry_t wr_entry
);
    dir_entry_t table_q [LINES];
    dir_entry_t table_d [LINES];

    always_comb begin
        for (int i = 0; i < LINES; i++) begin
            table_d[i] = table_q[i];
        end
        if (wr_en) begin
            table_d[wr_line] = wr_entry;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                table_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < LINES; i++) begin
                table_q[i] <= table_d[i];
            end
        end
    end

    assign rd_entry = table_q[rd_line];

    // R3 / R7: a dirty record always names exactly one holder
    a_r3_dirty_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_entry.dirty) |-> ($countones(wr_entry.present) == 1));
endmodule

// File: rtl/coh_ack_tracker.sv
module coh_ack_tracker
    import coh_dir_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  node_mask_t load_mask,
    input  node_mask_t ack,
    output logic       all_done
);
    typedef struct packed {
        node_mask_t       pend;
        logic [CNT_W-1:0] cnt;
    } trk_regs_t;

    trk_regs_t r_q, r_d;

    function automatic logic [CNT_W-1:0] pop(input node_mask_t m);
        logic [CNT_W-1:0] s;
        s = '0;
        for (int i = 0; i < NODES; i++) begin
            s = s + CNT_W'(m[i]);
        end
        return s;
    endfunction

    always_comb begin
        r_d = r_q;
        if (load) begin
            r_d.pend = load_mask;
            r_d.cnt  = pop(load_mask);
        end else begin
            r_d.pend = r_q.pend & ~ack;
            r_d.cnt  = r_q.cnt - pop(r_q.pend & ack);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign all_done = (r_q.cnt == '0);

    // R5: outstanding count tracks the pending set exactly
    a_r5_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt == CNT_W'($countones(r_q.pend)));
    // R5: without a new load the outstanding count never grows
    a_r5_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (r_q.cnt <= $past(r_q.cnt)));
endmodule

// File: rtl/coh_dir_fsm.sv
module coh_dir_fsm
    import coh_dir_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic       req_write,
    input  node_id_t   req_node,
    input  line_idx_t  req_line,
    output line_idx_t  rd_line,
    input  dir_entry_t rd_entry,
    output logic       wr_en,
    output line_idx_t  wr_line,
    output dir_entry_t wr_entry,
    output logic       trk_load,
    output node_mask_t trk_mask,
    input  logic       trk_done,
    output line_idx_t  txn_line,
    output logic       mem_rd_valid,
    output logic       mem_wr_valid,
    output line_data_t mem_wr_data,
    input  logic       mem_done,
    input  line_data_t mem_rd_data,
    output logic       recall_valid,
    output logic       recall_excl,
    output node_id_t   recall_node,
    input  logic       recall_done,
    input  line_data_t recall_data,
    output node_mask_t inv_valid,
    output logic       grant_valid,
    output logic       grant_write,
    output node_id_t   grant_node,
    output line_idx_t  grant_line,
    output line_data_t grant_data
);
    typedef struct packed {
        dir_state_e state;
        logic       write;
        node_id_t   node;
        line_idx_t  line;
        line_data_t data;
        dir_entry_t next_entry;
        node_mask_t inv_mask;
        node_id_t   owner;
        logic       excl;
    } fsm_regs_t;

    fsm_regs_t r_q, r_d;
    node_mask_t req_bit;
    node_id_t   owner_idx;

    always_comb begin
        owner_idx = '0;
        for (int i = 0; i < NODES; i++) begin
            if (rd_entry.present[i]) owner_idx = node_id_t'(i);
        end
    end

    assign req_bit = node_mask_t'(1) << r_q.node;

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.write = req_write;
                    r_d.node  = req_node;
                    r_d.line  = req_line;
                    r_d.state = ST_DECIDE;
                end
            end
            ST_DECIDE: begin
                r_d.owner = owner_idx;
                r_d.excl  = r_q.write;
                if (rd_entry.dirty && rd_entry.present[r_q.node]) begin
                    r_d.next_entry = rd_entry;
                    r_d.data       = '0;
                    r_d.state      = ST_GRANT;
                end else if (rd_entry.dirty) begin
                    r_d.next_entry.dirty   = r_q.write;
                    r_d.next_entry.present = r_q.write ? req_bit
                                                       : (rd_entry.present | req_bit);
                    r_d.state = ST_RECALL;
                end else if (r_q.write) begin
                    r_d.inv_mask           = rd_entry.present & ~req_bit;
                    r_d.next_entry.dirty   = 1'b1;
                    r_d.next_entry.present = req_bit;
                    r_d.state = (|(rd_entry.present & ~req_bit)) ? ST_INV : ST_MEM_RD;
                end else begin
                    r_d.next_entry.dirty   = 1'b0;
                    r_d.next_entry.present = rd_entry.present | req_bit;
                    r_d.state = ST_MEM_RD;
                end
            end
            ST_INV: begin
                r_d.state = ST_WAIT_ACK;
            end
            ST_WAIT_ACK: begin
                if (trk_done) r_d.state = ST_MEM_RD;
            end
            ST_MEM_RD: begin
                if (mem_done) begin
                    r_d.data  = mem_rd_data;
                    r_d.state = ST_GRANT;
                end
            end
            ST_RECALL: begin
                if (recall_done) begin
                    r_d.data  = recall_data;
                    r_d.state = r_q.excl ? ST_GRANT : ST_MEM_WR;
                end
            end
            ST_MEM_WR: begin
                if (mem_done) r_d.state = ST_GRANT;
            end
            ST_GRANT: begin
                r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready    = (r_q.state == ST_IDLE);
    assign rd_line      = r_q.line;
    assign wr_en        = (r_q.state == ST_GRANT);
    assign wr_line      = r_q.line;
    assign wr_entry     = r_q.next_entry;
    assign trk_load     = (r_q.state == ST_INV);
    assign trk_mask     = r_q.inv_mask;
    assign txn_line     = r_q.line;
    assign mem_rd_valid = (r_q.state == ST_MEM_RD);
    assign mem_wr_valid = (r_q.state == ST_MEM_WR);
    assign mem_wr_data  = r_q.data;
    assign recall_valid = (r_q.state == ST_RECALL);
    assign recall_excl  = r_q.excl;
    assign recall_node  = r_q.owner;
    assign inv_valid    = (r_q.state == ST_INV) ? r_q.inv_mask : '0;
    assign grant_valid  = (r_q.state == ST_GRANT);
    assign grant_write  = r_q.write;
    assign grant_node   = r_q.node;
    assign grant_line   = r_q.line;
    assign grant_data   = r_q.data;

    // R10: grant lasts one cycle
    a_r10_grant_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |=> !grant_valid);
    // R5: a grant only once every invalidation is acknowledged
    a_r5_grant_acked: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> trk_done);
    // R4: invalidations are a single-cycle pulse
    a_r4_inv_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (|inv_valid) |=> (inv_valid == '0));
    // R10: recall and memory requests stay up until answered
    a_r10_recall_held: assert property (@(posedge clk) disable iff (!rst_n)
        (recall_valid && !recall_done) |=> recall_valid);
    a_r10_mem_held: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd_valid || mem_wr_valid) && !mem_done) |=> (mem_rd_valid || mem_wr_valid));
    // R9: an accepted request makes the controller busy
    a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // R7: a recall never targets the requester
    a_r7_recall_not_self: assert property (@(posedge clk) disable iff (!rst_n)
        recall_valid |-> (recall_node != r_q.node));
endmodule

// File: rtl/coh_home_dir.sv
module coh_home_dir
    import coh_dir_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [NODE_W-1:0]   req_node,
    input  logic [LINE_W-1:0]   req_line,
    output logic [LINE_W-1:0]   txn_line,
    output logic                mem_rd_valid,
    output logic                mem_wr_valid,
    output logic [DATA_W-1:0]   mem_wr_data,
    input  logic                mem_done,
    input  logic [DATA_W-1:0]   mem_rd_data,
    output logic                recall_valid,
    output logic                recall_excl,
    output logic [NODE_W-1:0]   recall_node,
    input  logic                recall_done,
    input  logic [DATA_W-1:0]   recall_data,
    output logic [NODES-1:0]    inv_valid,
    input  logic [NODES-1:0]    inv_ack,
    output logic                grant_valid,
    output logic                grant_write,
    output logic [NODE_W-1:0]   grant_node,
    output logic [LINE_W-1:0]   grant_line,
    output logic [DATA_W-1:0]   grant_data
);
    line_idx_t  rd_line, wr_line;
    dir_entry_t rd_entry, wr_entry;
    logic       wr_en, trk_load, trk_done;
    node_mask_t trk_mask;

    coh_dir_store u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_line  (rd_line),
        .rd_entry (rd_entry),
        .wr_en    (wr_en),
        .wr_line  (wr_line),
        .wr_entry (wr_entry)
    );

    coh_ack_tracker u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (trk_load),
        .load_mask (trk_mask),
        .ack       (inv_ack),
        .all_done  (trk_done)
    );

    coh_dir_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_write    (req_write),
        .req_node     (req_node),
        .req_line     (req_line),
        .rd_line      (rd_line),
        .rd_entry     (rd_entry),
        .wr_en        (wr_en),
        .wr_line      (wr_line),
        .wr_entry     (wr_entry),
        .trk_load     (trk_load),
        .trk_mask     (trk_mask),
        .trk_done     (trk_done),
        .txn_line     (txn_line),
        .mem_rd_valid (mem_rd_valid),
        .mem_wr_valid (mem_wr_valid),
        .mem_wr_data  (mem_wr_data),
        .mem_done     (mem_done),
        .mem_rd_data  (mem_rd_data),
        .recall_valid (recall_valid),
        .recall_excl  (recall_excl),
        .recall_node  (recall_node),
        .recall_done  (recall_done),
        .recall_data  (recall_data),
        .inv_valid    (inv_valid),
        .grant_valid  (grant_valid),
        .grant_write  (grant_write),
        .grant_node   (grant_node),
        .grant_line   (grant_line),
        .grant_data   (grant_data)
    );
endmodule

// File: tb/coh_home_dir_test.sv
module coh_home_dir_test;
    import coh_dir_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [NODE_W-1:0] req_node = '0;
    logic [LINE_W-1:0] req_line = '0;
    logic req_ready;
    logic [LINE_W-1:0] txn_line;
    logic mem_rd_valid, mem_wr_valid;
    logic [DATA_W-1:0] mem_wr_data;
    logic mem_done = 1'b0;
    logic [DATA_W-1:0] mem_rd_data = '0;
    logic recall_valid, recall_excl;
    logic [NODE_W-1:0] recall_node;
    logic recall_done = 1'b0;
    logic [DATA_W-1:0] recall_data = '0;
    logic [NODES-1:0] inv_valid;
    logic [NODES-1:0] inv_ack = '0;
    logic grant_valid, grant_write;
    logic [NODE_W-1:0] grant_node;
    logic [LINE_W-1:0] grant_line;
    logic [DATA_W-1:0] grant_data;

    int checks = 0;
    int errors = 0;
    longint cycles = 0;

    logic [NODES-1:0]  pres_m [LINES];
    logic              dirty_m[LINES];
    logic [DATA_W-1:0] mem_m  [LINES];
    logic [DATA_W-1:0] own_m  [LINES];

    coh_home_dir uut (.*);

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int owner_of(input logic [NODES-1:0] p);
        int o = 0;
        for (int i = 0; i < NODES; i++) if (p[i]) o = i;
        return o;
    endfunction

    task automatic run_req(input bit wr, input int node, input int line, input bit junk);
        logic [NODES-1:0] p, bitn, exp_inv, pend, spur;
        bit d, self, exp_rd, exp_rec, exp_mwr, done;
        bit seen_rd, seen_rec, seen_mwr, seen_inv;
        int own, wt;
        logic [DATA_W-1:0] exp_data;
        p = pres_m[line]; d = dirty_m[line]; own = owner_of(p);
        bitn = NODES'(1) << node;
        self = d && p[node];
        exp_rd  = !self && !d;
        exp_rec = !self && d;
        exp_mwr = exp_rec && !wr;
        exp_inv = (!d && wr) ? (p & ~bitn) : '0;
        exp_data = self ? '0 : (d ? own_m[line] : mem_m[line]);
        seen_rd = 0; seen_rec = 0; seen_mwr = 0; seen_inv = 0; done = 0;
        pend = '0; spur = '0; wt = 0;

        @(negedge clk);
        chk(req_ready == 1'b1, "R9", "ready before request", req_ready, 1);
        req_valid = 1'b1; req_write = wr; req_node = NODE_W'(node); req_line = LINE_W'(line);
        @(negedge clk);
        req_valid = 1'b0;
        for (int c = 0; c < 400 && !done; c++) begin
            mem_done = 1'b0; recall_done = 1'b0; inv_ack = '0;
            if (junk) begin
                req_valid = 1'b1; req_write = ~wr;
                req_node = NODE_W'(node ^ 1); req_line = LINE_W'(line + 1);
            end
            if (grant_valid) begin
                done = 1; req_valid = 1'b0;
                chk(grant_node == NODE_W'(node), "R10", "grant node", grant_node, node);
                chk(grant_line == LINE_W'(line), "R10", "grant line", grant_line, line);
                chk(grant_write == wr, "R6", "grant write flag", grant_write, wr);
                if (self)
                    chk(grant_data == exp_data && !seen_rd && !seen_rec && !seen_inv, "R8",
                        "owner regrant data/no messages", grant_data, exp_data);
                else if (d && !wr)
                    chk(grant_data == exp_data, "R3", "recalled read data", grant_data, exp_data);
                else if (d)
                    chk(grant_data == exp_data, "R7", "recalled write data", grant_data, exp_data);
                else
                    chk(grant_data == exp_data, "R2", "memory data", grant_data, exp_data);
                chk(seen_rd == exp_rd, "R2", "memory read issued", seen_rd, exp_rd);
                chk(seen_rec == exp_rec, "R3", "recall issued", seen_rec, exp_rec);
                chk(seen_mwr == exp_mwr, exp_mwr ? "R3" : "R7", "memory write-back issued",
                    seen_mwr, exp_mwr);
                chk(seen_inv == (exp_inv != 0), "R4", "invalidation issued", seen_inv, exp_inv != 0);
                chk(pend == '0, "R5", "grant before all acks", pend, 0);
            end else begin
                chk(req_ready == 1'b0, "R9", "ready while busy", req_ready, 0);
                if (mem_rd_valid || mem_wr_valid || recall_valid || inv_valid != 0)
                    chk(txn_line == LINE_W'(line), "R10", "transaction line", txn_line, line);
                if (mem_rd_valid) begin
                    if (wt == 0) begin
                        mem_done = 1'b1; mem_rd_data = mem_m[line];
                        seen_rd = 1; wt = int'($urandom % 3);
                    end else wt--;
                end
                if (mem_wr_valid) begin
                    if (wt == 0) begin
                        chk(mem_wr_data == own_m[line], "R3", "write-back data",
                            mem_wr_data, own_m[line]);
                        mem_done = 1'b1; seen_mwr = 1; wt = int'($urandom % 3);
                    end else wt--;
                end
                if (recall_valid) begin
                    if (wt == 0) begin
                        chk(recall_node == NODE_W'(own), wr ? "R7" : "R3", "recall target",
                            recall_node, own);
                        chk(recall_excl == wr, wr ? "R7" : "R3", "recall kind", recall_excl, wr);
                        recall_done = 1'b1; recall_data = own_m[line];
                        seen_rec = 1; wt = int'($urandom % 3);
                    end else wt--;
                end
                if (inv_valid != 0) begin
                    chk(!seen_inv && inv_valid == exp_inv, "R4", "invalidation mask",
                        inv_valid, exp_inv);
                    seen_inv = 1; pend = inv_valid; spur = ~inv_valid;
                end else if (pend != 0) begin
                    if ($urandom % 2 == 0) begin
                        for (int k = 0; k < 64; k++) begin
                            int i = int'($urandom % NODES);
                            if (pend[i]) begin
                                inv_ack[i] = 1'b1; pend[i] = 1'b0; break;
                            end
                        end
                    end
                    if ($urandom % 3 == 0) inv_ack = inv_ack | (spur & NODES'($urandom));
                end
            end
            @(negedge clk);
        end
        mem_done = 1'b0; recall_done = 1'b0; inv_ack = '0; req_valid = 1'b0;
        chk(done, "R10", "grant seen", done, 1);
        chk(grant_valid == 1'b0 && req_ready == 1'b1, "R10", "single-cycle grant, ready back",
            {grant_valid, req_ready}, 2'b01);
        if (!self) begin
            if (!d && !wr) pres_m[line] = p | bitn;
            else if (d && !wr) begin
                pres_m[line] = p | bitn; dirty_m[line] = 1'b0; mem_m[line] = own_m[line];
            end else begin
                pres_m[line] = bitn; dirty_m[line] = 1'b1; own_m[line] = $urandom;
            end
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_0d1e));
        for (int i = 0; i < LINES; i++) begin
            pres_m[i] = '0; dirty_m[i] = 1'b0;
            mem_m[i] = DATA_W'(i) * 32'h0101_0101 ^ 32'hA5A5_0000;
            own_m[i] = '0;
        end
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        chk({grant_valid, mem_rd_valid, mem_wr_valid, recall_valid} == 4'b0 && inv_valid == '0,
            "R1", "outputs idle", {grant_valid, mem_rd_valid, mem_wr_valid, recall_valid}, 0);

        // R2 clean reads, then R4/R5/R6 invalidating write
        run_req(0, 2, 3, 0);
        run_req(0, 5, 3, 0);
        run_req(1, 2, 3, 0);
        // R3 read of a dirty line
        run_req(0, 6, 3, 0);
        // R4/R5 write with two sharers
        run_req(1, 0, 3, 0);
        // R7 write to a line dirty elsewhere
        run_req(1, 7, 3, 0);
        // R8 owner re-requests
        run_req(0, 7, 3, 0);
        run_req(1, 7, 3, 0);
        // R4 write with no other sharer, top line; R1 fresh line is clean
        run_req(1, 1, LINES - 1, 0);
        run_req(0, 4, LINES - 1, 0);
        // R9 requests offered while busy are not taken
        run_req(1, 3, 10, 1);
        run_req(0, 2, 11, 0);

        for (int n = 0; n < 300; n++) begin
            run_req(bit'($urandom % 2), int'($urandom % NODES), int'($urandom % 8),
                    bit'($urandom % 4 == 0));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule